// File: doc/BRIEF.md
# Supply Supervisor and Rail Status Flags

This block sits behind the digitised comparators of a multi-rail regulator and turns their raw flags into the supervisory and status outputs of the part. It watches a flag that reports the input supply below the reset threshold. From that flag it drives a complementary reset pair towards a processor. Once the supply recovers, the reset pair is held active for a minimum time counted on a reference clock. The minimum time is a parameter given in clock cycles.

The block also produces power-good flags. One flag covers the switching rail and has an always-inverted copy. One flag covers both linear rails together. Each flag is forced low while its rail is disabled. All inputs arrive asynchronously and pass through a two-flop synchroniser before any decision is made. A synchronous active-low reset puts every output into its reset or fault state.

Top module: `supply_supervisor`

## Requirements
- R1: While `supply_low_i` is high, `rst_hi_o` is high. A rise of `supply_low_i` sampled at one rising edge drives `rst_hi_o` high by the third rising edge, counting that edge as the first.
- R2: Let `supply_low_i` be low at a rising edge, and stay low from then on. `rst_hi_o` then stays high through the next HOLD_CYCLES+2 rising edges. It goes low at the (HOLD_CYCLES+3)-th edge, counting the first low-sampling edge as edge 1.
- R3: `rst_lo_n_o` is always the inverse of `rst_hi_o`.
- R4: `ldo_pg_o` is low if either `ldo_a_ok_i` or `ldo_b_ok_i` is low. The delay is 3 rising edges from the edge that samples the input.
- R5: `ldo_pg_o` is low whenever `ldo_en_i` is low. The delay is 3 rising edges. With enable and both window flags high, it is high after the same delay.
- R6: `buck_pg_o` is high only when both `buck_en_i` and `buck_ok_i` are high. The delay is 3 rising edges.
- R7: `buck_pg_n_o` is always the inverse of `buck_pg_o`.
- R8: If the supply dips below threshold again during the hold, the hold restarts. The full HOLD_CYCLES window is counted again from the last recovery, as in R2.
- R9: While `rst_n` is low at a rising edge, the next outputs are: `rst_hi_o`=1, `rst_lo_n_o`=0, `buck_pg_o`=0, `buck_pg_n_o`=1, `ldo_pg_o`=0. After `rst_n` is released with the supply already good, the full hold of R2 still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for synchronisers and hold counter |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_low_i | input | 1 | Supply below reset threshold (asynchronous) |
| buck_en_i | input | 1 | Switching rail enable (asynchronous) |
| buck_ok_i | input | 1 | Switching rail inside regulation window (asynchronous) |
| ldo_en_i | input | 1 | Linear rails enable (asynchronous) |
| ldo_a_ok_i | input | 1 | First linear rail in regulation (asynchronous) |
| ldo_b_ok_i | input | 1 | Second linear rail in regulation (asynchronous) |
| rst_hi_o | output | 1 | Active-high reset |
| rst_lo_n_o | output | 1 | Active-low reset, inverse of rst_hi_o |
| buck_pg_o | output | 1 | Switching rail power good |
| buck_pg_n_o | output | 1 | Inverse of buck_pg_o |
| ldo_pg_o | output | 1 | Linear rails power good |

## Verification
The hardest situation to reach is a second supply dip that lands in the middle of a running hold. It must land late enough that the counter has visibly moved from its preload. A test that only checks the final release time cannot tell a reload from a counter that simply continues. The bench therefore runs a directed sequence: recovery, a wait of about half the hold, a short dip, then a check that reset is still high one edge before the full window from the second recovery ends. A cycle-by-cycle behavioural model then follows random input traffic, including one-cycle dips, and compares every output on every clock.

// File: rtl/supervisor_pkg.sv
// Shared indices and reset values for the supervisor's synchronised input vector.
package supervisor_pkg;
    localparam int SIG_SUPPLY_LOW = 0;
    localparam int SIG_BUCK_EN    = 1;
    localparam int SIG_BUCK_OK    = 2;
    localparam int SIG_LDO_EN     = 3;
    localparam int SIG_LDO_A_OK   = 4;
    localparam int SIG_LDO_B_OK   = 5;
    localparam int SIG_COUNT      = 6;
    // Safe value at reset: supply reported low, every rail off / out of window.
    localparam logic [SIG_COUNT-1:0] SIG_SAFE = 6'b00_0001;
endpackage

// File: rtl/sv_sync.sv
// Multi-bit, multi-stage synchroniser for independent asynchronous flags.
// Assumes each bit is an unrelated level signal (no bus coherency needed).
// The stage count is a parameter; at least two stages are expected.
module sv_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage [STAGES];

    // First stage captures the raw asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= RESET_VAL;
        else        stage[0] <= din;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Each further stage re-samples the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[g] <= RESET_VAL;
                else        stage[g] <= stage[g-1];
            end
        end
    endgenerate

    assign dout = stage[STAGES-1];
endmodule

// File: rtl/sv_reset_hold.sv
// Reset pulse stretcher: holds reset active while the supply is low and for
// HOLD_CYCLES clocks after it recovers. Any new dip reloads the counter.
// Assumes supply_low is already synchronised to clk.
module sv_reset_hold #(
    parameter int HOLD_CYCLES = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low,
    output logic rst_act
);
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYCLES);

    logic [CNT_W-1:0] cnt;

    // Reload on reset or dip, else count down; reset clears once the count is spent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= CNT_LOAD;
            rst_act <= 1'b1;
        end else if (supply_low) begin
            cnt     <= CNT_LOAD;
            rst_act <= 1'b1;
        end else if (cnt != '0) begin
            cnt     <= cnt - CNT_W'(1);
            rst_act <= 1'b1;
        end else begin
            rst_act <= 1'b0;
        end
    end

    AST_RST_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> rst_act); // R1
    AST_HOLD_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        (!supply_low && cnt != '0) |=> rst_act); // R2
    AST_HOLD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> (cnt == CNT_LOAD)); // R8
endmodule

// File: rtl/sv_power_good.sv
// Registered power-good flags for the switching rail and the linear pair.
// A flag is high only when its rail is enabled and every monitored output
// is inside its window. Assumes all inputs are synchronised to clk.
module sv_power_good (
    input  logic clk,
    input  logic rst_n,
    input  logic buck_en,
    input  logic buck_ok,
    input  logic ldo_en,
    input  logic ldo_a_ok,
    input  logic ldo_b_ok,
    output logic buck_pg,
    output logic ldo_pg
);
    // Combine enable and window flags per rail; reset forces the fault state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buck_pg <= 1'b0;
            ldo_pg  <= 1'b0;
        end else begin
            buck_pg <= buck_en & buck_ok;
            ldo_pg  <= ldo_en & ldo_a_ok & ldo_b_ok;
        end
    end

    AST_LDO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!ldo_a_ok || !ldo_b_ok) |=> !ldo_pg); // R4
    AST_LDO_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !ldo_en |=> !ldo_pg); // R5
    AST_BUCK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!buck_en || !buck_ok) |=> !buck_pg); // R6
endmodule

// File: rtl/supply_supervisor.sv
// Top of the supply supervisor. Synchronises the comparator and enable
// flags, stretches the reset pulse, and drives the power-good flags with
// their complementary copies. Assumes clk runs whenever the supply is
// above the lockout level. HOLD_CYCLES is the minimum reset width in clk cycles.
module supply_supervisor
    import supervisor_pkg::*;
#(
    parameter int HOLD_CYCLES = 25000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low_i,
    input  logic buck_en_i,
    input  logic buck_ok_i,
    input  logic ldo_en_i,
    input  logic ldo_a_ok_i,
    input  logic ldo_b_ok_i,
    output logic rst_hi_o,
    output logic rst_lo_n_o,
    output logic buck_pg_o,
    output logic buck_pg_n_o,
    output logic ldo_pg_o
);
    logic [SIG_COUNT-1:0] raw_vec;
    logic [SIG_COUNT-1:0] sync_vec;
    logic                 rst_act;
    logic                 buck_pg;
    logic                 ldo_pg;

    // Pack the asynchronous inputs into the synchroniser vector.
    always_comb begin
        raw_vec                 = '0;
        raw_vec[SIG_SUPPLY_LOW] = supply_low_i;
        raw_vec[SIG_BUCK_EN]    = buck_en_i;
        raw_vec[SIG_BUCK_OK]    = buck_ok_i;
        raw_vec[SIG_LDO_EN]     = ldo_en_i;
        raw_vec[SIG_LDO_A_OK]   = ldo_a_ok_i;
        raw_vec[SIG_LDO_B_OK]   = ldo_b_ok_i;
    end

    sv_sync #(
        .WIDTH    (SIG_COUNT),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(SIG_SAFE)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_vec),
        .dout (sync_vec)
    );

    sv_reset_hold #(
        .HOLD_CYCLES(HOLD_CYCLES)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_low(sync_vec[SIG_SUPPLY_LOW]),
        .rst_act   (rst_act)
    );

    sv_power_good u_pg (
        .clk     (clk),
        .rst_n   (rst_n),
        .buck_en (sync_vec[SIG_BUCK_EN]),
        .buck_ok (sync_vec[SIG_BUCK_OK]),
        .ldo_en  (sync_vec[SIG_LDO_EN]),
        .ldo_a_ok(sync_vec[SIG_LDO_A_OK]),
        .ldo_b_ok(sync_vec[SIG_LDO_B_OK]),
        .buck_pg (buck_pg),
        .ldo_pg  (ldo_pg)
    );

    // Drive each output pair from one register so the copies never disagree.
    assign rst_hi_o    = rst_act;
    assign rst_lo_n_o  = ~rst_act;
    assign buck_pg_o   = buck_pg;
    assign buck_pg_n_o = ~buck_pg;
    assign ldo_pg_o    = ldo_pg;

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (rst_hi_o && !buck_pg_o && !ldo_pg_o)); // R9
endmodule

// File: tb/sim_supply_supervisor.sv
module sim_supply_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_low = 1'b1, buck_en = 1'b0, buck_ok = 1'b0;
    logic ldo_en = 1'b0, ldo_a = 1'b0, ldo_b = 1'b0;
    logic rst_hi, rst_lo_n, buck_pg, buck_pg_n, ldo_pg;

    int n_tests = 0;
    int n_fail  = 0;
    bit model_on = 1'b0;

    // behavioural reference state
    bit q0 [6];
    bit q1 [6];
    bit cur [6];
    integer m_cnt = HOLD;
    bit m_rst = 1'b1, m_bpg = 1'b0, m_lpg = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    supply_supervisor #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n),
        .supply_low_i(supply_low), .buck_en_i(buck_en), .buck_ok_i(buck_ok),
        .ldo_en_i(ldo_en), .ldo_a_ok_i(ldo_a), .ldo_b_ok_i(ldo_b),
        .rst_hi_o(rst_hi), .rst_lo_n_o(rst_lo_n),
        .buck_pg_o(buck_pg), .buck_pg_n_o(buck_pg_n), .ldo_pg_o(ldo_pg)
    );

    task automatic chk(string req, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    // Reference model: two sample delays, then the rules of R1..R9.
    always @(posedge clk) begin
        cur = '{supply_low, buck_en, buck_ok, ldo_en, ldo_a, ldo_b};
        if (!rst_n) begin
            q0 = '{1, 0, 0, 0, 0, 0};
            q1 = '{1, 0, 0, 0, 0, 0};
            m_cnt = HOLD; m_rst = 1; m_bpg = 0; m_lpg = 0;
        end else begin
            m_bpg = q1[1] && q1[2];
            m_lpg = q1[3] && q1[4] && q1[5];
            if (q1[0]) begin m_cnt = HOLD; m_rst = 1; end
            else if (m_cnt > 0) begin m_cnt = m_cnt - 1; m_rst = 1; end
            else m_rst = 0;
            q1 = q0;
            q0 = cur;
        end
    end

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (model_on) begin
            chk("R1/R2/R8 rst_hi model", rst_hi, m_rst);
            chk("R3 rst_lo_n complement", rst_lo_n, ~rst_hi);
            chk("R6 buck_pg model", buck_pg, m_bpg);
            chk("R7 buck_pg_n complement", buck_pg_n, ~buck_pg);
            chk("R4/R5 ldo_pg model", ldo_pg, m_lpg);
        end
    end

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R9: reset state with inputs set to the good values
        supply_low = 0; buck_en = 1; buck_ok = 1; ldo_en = 1; ldo_a = 1; ldo_b = 1;
        edges(3);
        chk("R9 reset rst_hi", rst_hi, 1'b1);
        chk("R9 reset rst_lo_n", rst_lo_n, 1'b0);
        chk("R9 reset buck_pg", buck_pg, 1'b0);
        chk("R9 reset buck_pg_n", buck_pg_n, 1'b1);
        chk("R9 reset ldo_pg", ldo_pg, 1'b0);
        rst_n = 1;
        model_on = 1;
        // R2/R9: full hold after release; the first released edge is edge 1
        edges(HOLD + 2);
        chk("R2 hold still active", rst_hi, 1'b1);
        chk("R6 buck_pg good", buck_pg, 1'b1);
        chk("R5 ldo_pg good", ldo_pg, 1'b1);
        edges(1);
        chk("R2 hold released", rst_hi, 1'b0);
        // R6/R7: disable switching rail
        buck_en = 0;
        edges(2);
        chk("R10-latency buck_pg not yet (R6)", buck_pg, 1'b1);
        edges(1);
        chk("R6 buck_pg off when disabled", buck_pg, 1'b0);
        chk("R7 buck_pg_n high", buck_pg_n, 1'b1);
        buck_en = 1; buck_ok = 0;
        edges(3);
        chk("R6 buck_pg off out of window", buck_pg, 1'b0);
        buck_ok = 1;
        // R4: one linear rail out of window
        ldo_b = 0;
        edges(3);
        chk("R4 ldo_pg low on rail B", ldo_pg, 1'b0);
        ldo_b = 1; ldo_a = 0;
        edges(3);
        chk("R4 ldo_pg low on rail A", ldo_pg, 1'b0);
        ldo_a = 1; ldo_en = 0;
        edges(3);
        chk("R5 ldo_pg low when disabled", ldo_pg, 1'b0);
        ldo_en = 1;
        // R1: single-cycle dip
        supply_low = 1;
        edges(1);
        supply_low = 0;
        edges(2);
        chk("R1 reset on dip", rst_hi, 1'b1);
        chk("R3 rst_lo_n low on dip", rst_lo_n, 1'b0);
        // R8: second dip in mid-hold reloads the window
        edges(HOLD / 2);
        supply_low = 1;
        edges(1);
        supply_low = 0;
        edges(HOLD + 2);
        chk("R8 reload keeps reset high", rst_hi, 1'b1);
        edges(1);
        chk("R8 release after reloaded hold", rst_hi, 1'b0);
        // random traffic under model comparison
        for (int i = 0; i < 2000; i++) begin
            supply_low = ($urandom_range(0, 99) < 3);
            buck_en = ($urandom_range(0, 9) != 0);
            buck_ok = ($urandom_range(0, 9) != 0);
            ldo_en  = ($urandom_range(0, 9) != 0);
            ldo_a   = ($urandom_range(0, 9) != 0);
            ldo_b   = ($urandom_range(0, 9) != 0);
            if (i == 1000) rst_n = 0;
            if (i == 1003) rst_n = 1;
            edges(1);
        end
        model_on = 0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule